// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces the addresses used to walk through a buffer in memory. It holds four registers: an index, a signed step (modifier), a window start (base) and a window size (length). The address output always shows the index. A request uses that address and then moves the index by the step register, or by a signed immediate sent with the request.

When the length is non-zero the index stays inside the window `[base, base+length)`. If the moved index lands at or beyond the window end, it is pulled back by one length. If it lands below the base, it is pushed forward by one length. A stream that writes one sample per request therefore overwrites the oldest entry once the ring is full, and software never has to check bounds. When the length is zero the index simply moves, modulo 2^AW. The four registers are loaded through a small write port.

Top module: `circ_agen`

## Requirements
- R1: While rst_ni is low and after its release, the index, step, base and length registers are all zero, so addr_o reads 0.
- R2: A write with wr_en_i high loads wr_data_i into the register chosen by wr_sel_i (0 index, 1 step, 2 base, 3 length). The write shows in the next cycle.
- R3: A base write (wr_sel_i = 2) also loads the index with the same value.
- R4: addr_o always shows the current index. A request (req_i high) leaves the address of that cycle unchanged. The moved index appears on addr_o in the following cycle (post-modify).
- R5: The move amount is the signed step register when use_imm_i is 0, and the signed imm_i when use_imm_i is 1.
- R6: With length zero the new index is index + amount, modulo 2^AW, with no wrap.
- R7: With length non-zero, a sum at or above base+length (computed without overflow) is reduced by length.
- R8: With length non-zero, a sum below base is increased by length. For an index in the window and an amount no larger than length, the result stays in the window.
- R9: With no request and no write, the index holds its value.
- R10: If a write and a request fall in the same cycle, the write takes effect and the request is ignored.
- R11: With step +1 over a window of L entries, L requests return the index to base, so the (L+1)-th access reuses the oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 index, 1 step, 2 base, 3 length |
| wr_data_i | input | AW | Write data |
| req_i | input | 1 | Access request, post-modifies the index |
| use_imm_i | input | 1 | Use imm_i instead of the step register |
| imm_i | input | AW | Signed immediate move amount |
| addr_o | output | AW | Current address (index) |

## Verification
The hardest case to reach from the ports is a window that ends exactly at the top of the address space. There, index plus step carries out of AW bits, and the wrap must still work on the full-width sum. Random windows almost never land there. A directed sequence therefore places base at 2^32-16 with length 16 and steps past the end in both directions. Random trials then cover windows up to 64 entries, with steps and immediates of either sign up to the full length.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
  typedef enum logic [1:0] {
    SEL_IDX  = 2'd0,
    SEL_STEP = 2'd1,
    SEL_BASE = 2'd2,
    SEL_LEN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cag_regs.sv
module cag_regs
  import circ_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [AW-1:0] upd_idx_i,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] len_o
);
  logic [AW-1:0] idx_q, step_q, base_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      step_q <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else if (wr_en_i) begin
      // write wins over a concurrent update
      unique case (reg_sel_e'(wr_sel_i))
        SEL_IDX:  idx_q <= wr_data_i;
        SEL_STEP: step_q <= wr_data_i;
        SEL_BASE: begin
          base_q <= wr_data_i;
          idx_q  <= wr_data_i;
        end
        SEL_LEN:  len_q <= wr_data_i;
        default:  ;
      endcase
    end else if (upd_en_i) begin
      idx_q <= upd_idx_i;
    end
  end

  assign idx_o  = idx_q;
  assign step_o = step_q;
  assign base_o = base_q;
  assign len_o  = len_q;

  AST_BASE_LOADS_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2) |=> (idx_q == $past(wr_data_i) && base_q == idx_q)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !upd_en_i) |=> $stable(idx_q)); // R9
endmodule

// File: rtl/cag_step.sv
module cag_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] amt_i,
  output logic [AW-1:0] nxt_o
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum, win_lo, win_hi, wrapped;

  always_comb begin
    sum    = $signed({2'b00, idx_i}) + $signed({{2{amt_i[AW-1]}}, amt_i});
    win_lo = $signed({2'b00, base_i});
    win_hi = $signed({2'b00, base_i}) + $signed({2'b00, len_i});
    wrapped = sum;
    if (len_i != '0) begin
      if (sum >= win_hi)     wrapped = sum - $signed({2'b00, len_i});
      else if (sum < win_lo) wrapped = sum + $signed({2'b00, len_i});
    end
    nxt_o = wrapped[AW-1:0];
  end
endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import circ_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          req_i,
  input  logic          use_imm_i,
  input  logic [AW-1:0] imm_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] idx, step, base, len, amt, nxt;
  logic          upd_en;

  assign amt    = use_imm_i ? imm_i : step;
  assign upd_en = req_i && !wr_en_i;

  cag_regs #(.AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (upd_en),
    .upd_idx_i (nxt),
    .idx_o     (idx),
    .step_o    (step),
    .base_o    (base),
    .len_o     (len)
  );

  cag_step #(.AW(AW)) u_step (
    .idx_i  (idx),
    .base_i (base),
    .len_i  (len),
    .amt_i  (amt),
    .nxt_o  (nxt)
  );

  assign addr_o = idx;

  // checker-side window view
  logic [AW:0]   win_hi;
  logic [AW-1:0] amt_mag;
  logic          in_win, amt_ok;
  assign win_hi  = {1'b0, base} + {1'b0, len};
  assign in_win  = ({1'b0, idx} >= {1'b0, base}) && ({1'b0, idx} < win_hi);
  assign amt_mag = amt[AW-1] ? (~amt + 1'b1) : amt;
  assign amt_ok  = amt_mag <= len;

  AST_STAYS_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && len != '0 && in_win && amt_ok) |=> in_win); // R8
  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && len == '0) |=> (addr_o == $past(addr_o + amt))); // R6
  AST_WRITE_BEATS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && req_i && wr_sel_i == 2'd1) |=> $stable(addr_o)); // R10
  AST_POST_MODIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && amt != '0 && len == '0) |=> (addr_o != $past(addr_o))); // R4
endmodule

// File: tb/circ_agen_tb.sv
module circ_agen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0;
  logic        use_imm = 1'b0;
  logic [31:0] imm = '0;
  logic [31:0] addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_idx = '0, m_step = '0, m_base = '0, m_len = '0;

  always #2 clk = ~clk;

  circ_agen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .req_i(req), .use_imm_i(use_imm), .imm_i(imm),
    .addr_o(addr)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp_v);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] amt);
    longint s, lo, hi;
    s  = longint'(m_idx) + longint'(signed'(amt));
    lo = longint'(m_base);
    hi = lo + longint'(m_len);
    if (m_len != 0) begin
      if (s >= hi) s = s - longint'(m_len);
      else if (s < lo) s = s + longint'(m_len);
    end
    return s[31:0];
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_idx = d;
      2'd1: m_step = d;
      2'd2: begin m_base = d; m_idx = d; end
      default: m_len = d;
    endcase
  endtask

  task automatic acc(input string rq, input bit ui, input logic [31:0] iv);
    logic [31:0] amt;
    req = 1'b1; use_imm = ui; imm = iv;
    chk({rq, " R4 pre"}, addr, m_idx);
    amt = ui ? iv : m_step;
    @(negedge clk);
    req = 1'b0; use_imm = 1'b0;
    m_idx = model_next(amt);
    chk(rq, addr, m_idx);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in reset", addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", addr, 32'h0);

    // R2: register writes and R6 linear mode
    wr(2'd0, 32'h0000_1000);
    chk("R2 index write", addr, 32'h0000_1000);
    wr(2'd1, 32'h0000_0004);
    acc("R6 linear step", 1'b0, 32'h0);
    acc("R5 R6 linear imm neg", 1'b1, 32'hFFFF_FFF0);
    wr(2'd0, 32'hFFFF_FFFE);
    acc("R6 linear wraps 2^32", 1'b0, 32'h0);

    // R9 hold
    repeat (3) @(negedge clk);
    chk("R9 idle hold", addr, m_idx);

    // R3 base write loads index
    wr(2'd3, 32'd8);
    wr(2'd2, 32'h0000_0200);
    chk("R3 base loads index", addr, 32'h0000_0200);

    // R7 / R8 directed
    wr(2'd0, 32'h0000_0206);
    acc("R7 wrap top", 1'b1, 32'd3);
    chk("R7 value", addr, 32'h0000_0201);
    acc("R8 wrap bottom", 1'b1, 32'hFFFF_FFFD);
    chk("R8 value", addr, 32'h0000_0206);
    acc("R7 exact end", 1'b1, 32'd2);
    chk("R7 exact end value", addr, 32'h0000_0200);

    // R10 write and request together
    req = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'd1;
    @(negedge clk);
    req = 1'b0; wr_en = 1'b0; m_step = 32'd1;
    chk("R10 request ignored", addr, 32'h0000_0200);
    acc("R10 new step used", 1'b0, 32'h0);

    // R11 ring sweep
    wr(2'd2, 32'h0000_0200);
    for (int k = 0; k < 8; k++) acc("R11 sweep", 1'b0, 32'h0);
    chk("R11 back to oldest", addr, 32'h0000_0200);

    // top-of-space window with carry out
    wr(2'd3, 32'd16);
    wr(2'd2, 32'hFFFF_FFF0);
    wr(2'd0, 32'hFFFF_FFFE);
    acc("R7 carry out", 1'b1, 32'd3);
    chk("R7 carry out value", addr, 32'hFFFF_FFF1);
    acc("R8 top window", 1'b1, 32'hFFFF_FFF0);
    chk("R8 top window value", addr, 32'hFFFF_FFF1);

    // random windows
    for (int t = 0; t < 60; t++) begin
      logic [31:0] ln, bs, ix, st;
      longint span;
      ln = 32'd1 + ($urandom % 64);
      span = 64'h1_0000_0000 - longint'(ln);
      bs = ($urandom % 4 == 0) ? span[31:0] : 32'($urandom % 32'hFFFF_FF00);
      ix = bs + ($urandom % ln);
      st = 32'($signed($urandom % (2 * ln + 1)) - $signed(ln));
      wr(2'd3, ln);
      wr(2'd2, bs);
      wr(2'd0, ix);
      wr(2'd1, st);
      for (int k = 0; k < 20; k++) begin
        if ($urandom % 2) begin
          logic [31:0] iv;
          iv = 32'($signed($urandom % (2 * ln + 1)) - $signed(ln));
          acc("R5 R7 R8 random imm", 1'b1, iv);
        end else begin
          acc("R5 R7 R8 random step", 1'b0, 32'h0);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule